// File: doc/BRIEF.md
# Integer ALU with Instruction Decode

This block takes a 32-bit instruction word together with the values of its two source registers, recognises the register-register and register-immediate integer operations (arithmetic, bitwise logic, compare and shift), and produces the result, the index of the destination register, a write-enable and an overflow-trap request. The outputs are registered, so a result appears one clock after its instruction is presented. The register file, branches, memory access and multiply/divide live elsewhere. Any encoding outside the supported set raises a reserved-instruction flag and never writes.

Trapping adds and subtracts raise the trap on two's-complement overflow and suppress the write. Their wrapping variants never trap. Arithmetic and compare immediates are sign-extended. Bitwise immediates are zero-extended.

Top module: `int_alu_dec`

## Requirements
- R1: While reset is asserted, and after it is released until the first instruction result, result_o, dest_o, wr_en_o, ovf_trap_o and rsvd_o are all zero.
- R2: Outputs reflect the instruction and operands sampled at the previous rising clock edge (one cycle latency).
- R3: With opcode bits [31:26] = 0, funct bits [5:0] select add 0x20, addu 0x21, sub 0x22, subu 0x23, and 0x24, or 0x25, xor 0x26 and nor 0x27, computed on rs_val_i and rt_val_i. The destination index is bits [15:11].
- R4: add, sub and addi (opcode 0x08) assert ovf_trap_o and hold wr_en_o low on signed overflow. addu, subu and addiu (opcode 0x09) never trap and always write. result_o carries the wrapped sum or difference in every case.
- R5: slt (funct 0x2A) compares signed, sltu (funct 0x2B) compares unsigned, slti (opcode 0x0A) compares signed against the sign-extended immediate. The result is 1 or 0.
- R6: Shifts act on rt_val_i. sll 0x00, srl 0x02 and sra 0x03 take the distance from bits [10:6]. sllv 0x04, srlv 0x06 and srav 0x07 take it from the low 5 bits of rs_val_i. Logical right shifts fill with zeros and arithmetic right shifts fill with the sign bit.
- R7: Immediate operations take rs_val_i and the immediate in bits [15:0], and write to the index in bits [20:16]. addi, addiu and slti sign-extend the immediate. andi 0x0C, ori 0x0D and xori 0x0E zero-extend it.
- R8: Any other opcode, or opcode 0 with any other funct, sets rsvd_o and forces wr_en_o, ovf_trap_o, result_o and dest_o to zero.
- R9: At most one of wr_en_o, ovf_trap_o and rsvd_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | DATA_W | Value of the first source register |
| rt_val_i | input | DATA_W | Value of the second source register |
| result_o | output | DATA_W | Operation result |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write the result to the destination register |
| ovf_trap_o | output | 1 | Signed-overflow trap request |
| rsvd_o | output | 1 | Reserved or unsupported encoding |

## Verification
Every supported operation is tried with operands chosen to separate look-alikes. Sums just past the signed maximum tell the trapping forms from the wrapping ones. Minus one against one tells the signed compare from the unsigned one. Immediates with bit 15 set tell sign extension from zero extension. Sign-bit-set shift operands tell logical right shifts from arithmetic ones, and rs values with set bits above bit 4 confirm that variable shifts use only the low five bits. Unsupported opcodes and funct codes next to supported ones show the reserved path, and a mid-run reset together with a before-and-after sample around a clock edge shows the clearing and the one-cycle latency.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_ADDI    = 6'h08;
  localparam logic [5:0] OPC_ADDIU   = 6'h09;
  localparam logic [5:0] OPC_SLTI    = 6'h0A;
  localparam logic [5:0] OPC_ANDI    = 6'h0C;
  localparam logic [5:0] OPC_ORI     = 6'h0D;
  localparam logic [5:0] OPC_XORI    = 6'h0E;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  localparam int IDX_W = 5;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef struct packed {
    alu_op_e          op;
    logic             src_imm;    // second operand is the immediate
    logic             imm_zext;   // zero-extend instead of sign-extend
    logic             shift_var;  // distance from rs value
    logic             trap_en;    // overflow requests a trap
    logic             legal;
    logic [IDX_W-1:0] dest;
  } dec_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import int_alu_pkg::*;
(
  input  logic [5:0]       opcode_i,
  input  logic [5:0]       funct_i,
  input  logic [IDX_W-1:0] rt_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output dec_ctl_t         ctl_o
);

  always_comb begin
    ctl_o           = '0;
    ctl_o.op        = ALU_ADD;
    ctl_o.legal     = 1'b1;
    if (opcode_i == OPC_SPECIAL) begin
      ctl_o.dest = rd_idx_i;
      unique case (funct_i)
        FN_ADD:  begin ctl_o.op = ALU_ADD; ctl_o.trap_en = 1'b1; end
        FN_ADDU: ctl_o.op = ALU_ADD;
        FN_SUB:  begin ctl_o.op = ALU_SUB; ctl_o.trap_en = 1'b1; end
        FN_SUBU: ctl_o.op = ALU_SUB;
        FN_AND:  ctl_o.op = ALU_AND;
        FN_OR:   ctl_o.op = ALU_OR;
        FN_XOR:  ctl_o.op = ALU_XOR;
        FN_NOR:  ctl_o.op = ALU_NOR;
        FN_SLT:  ctl_o.op = ALU_SLT;
        FN_SLTU: ctl_o.op = ALU_SLTU;
        FN_SLL:  ctl_o.op = ALU_SLL;
        FN_SRL:  ctl_o.op = ALU_SRL;
        FN_SRA:  ctl_o.op = ALU_SRA;
        FN_SLLV: begin ctl_o.op = ALU_SLL; ctl_o.shift_var = 1'b1; end
        FN_SRLV: begin ctl_o.op = ALU_SRL; ctl_o.shift_var = 1'b1; end
        FN_SRAV: begin ctl_o.op = ALU_SRA; ctl_o.shift_var = 1'b1; end
        default: begin ctl_o.legal = 1'b0; ctl_o.dest = '0; end
      endcase
    end else begin
      ctl_o.dest    = rt_idx_i;
      ctl_o.src_imm = 1'b1;
      unique case (opcode_i)
        OPC_ADDI:  begin ctl_o.op = ALU_ADD; ctl_o.trap_en = 1'b1; end
        OPC_ADDIU: ctl_o.op = ALU_ADD;
        OPC_SLTI:  ctl_o.op = ALU_SLT;
        OPC_ANDI:  begin ctl_o.op = ALU_AND; ctl_o.imm_zext = 1'b1; end
        OPC_ORI:   begin ctl_o.op = ALU_OR;  ctl_o.imm_zext = 1'b1; end
        OPC_XORI:  begin ctl_o.op = ALU_XOR; ctl_o.imm_zext = 1'b1; end
        default:   begin ctl_o.legal = 1'b0; ctl_o.dest = '0; ctl_o.src_imm = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  dec_ctl_t          ctl_i,
  input  logic [15:0]       imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);

  localparam int EXT_W = DATA_W - 16;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic [SH_W-1:0]   sh_amt;
  logic              sgn_a, sgn_b;

  always_comb begin
    imm_ext = ctl_i.imm_zext ? {{EXT_W{1'b0}}, imm_i} : {{EXT_W{imm_i[15]}}, imm_i};
    opnd_b  = ctl_i.src_imm ? imm_ext : rt_val_i;
    sh_amt  = ctl_i.shift_var ? rs_val_i[SH_W-1:0] : shamt_i;
    sum     = rs_val_i + opnd_b;
    diff    = rs_val_i - opnd_b;
    sgn_a   = rs_val_i[DATA_W-1];
    sgn_b   = opnd_b[DATA_W-1];
  end

  always_comb begin
    ovf_o = 1'b0;
    unique case (ctl_i.op)
      ALU_ADD:  begin result_o = sum;  ovf_o = (sgn_a == sgn_b) && (sum[DATA_W-1] != sgn_a); end
      ALU_SUB:  begin result_o = diff; ovf_o = (sgn_a != sgn_b) && (diff[DATA_W-1] != sgn_a); end
      ALU_AND:  result_o = rs_val_i & opnd_b;
      ALU_OR:   result_o = rs_val_i | opnd_b;
      ALU_XOR:  result_o = rs_val_i ^ opnd_b;
      ALU_NOR:  result_o = ~(rs_val_i | opnd_b);
      ALU_SLT:  result_o = {{(DATA_W-1){1'b0}}, ($signed(rs_val_i) < $signed(opnd_b))};
      ALU_SLTU: result_o = {{(DATA_W-1){1'b0}}, (rs_val_i < opnd_b)};
      ALU_SLL:  result_o = rt_val_i << sh_amt;
      ALU_SRL:  result_o = rt_val_i >> sh_amt;
      ALU_SRA:  result_o = DATA_W'($signed(rt_val_i) >>> sh_amt);
      default:  result_o = '0;
    endcase
  end

endmodule

// File: rtl/int_alu_dec.sv
module int_alu_dec
  import int_alu_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic [DATA_W-1:0] result_o,
  output logic [IDX_W-1:0]  dest_o,
  output logic              wr_en_o,
  output logic              ovf_trap_o,
  output logic              rsvd_o
);

  localparam int SH_W = 5;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  dec_ctl_t          ctl;
  logic [DATA_W-1:0] exe_res;
  logic              exe_ovf;
  logic              unused_rs_idx;

  assign unused_rs_idx = ^instr_i[25:21];

  alu_decode u_dec (
    .opcode_i (instr_i[31:26]),
    .funct_i  (instr_i[5:0]),
    .rt_idx_i (instr_i[20:16]),
    .rd_idx_i (instr_i[15:11]),
    .ctl_o    (ctl)
  );

  alu_exec #(.DATA_W(DATA_W), .SH_W(SH_W)) u_exe (
    .ctl_i    (ctl),
    .imm_i    (instr_i[15:0]),
    .shamt_i  (instr_i[10:6]),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .result_o (exe_res),
    .ovf_o    (exe_ovf)
  );

  // next state
  logic [DATA_W-1:0] res_d;
  logic [IDX_W-1:0]  dest_d;
  logic              we_d, trap_d, rsvd_d;

  always_comb begin
    res_d  = ctl.legal ? exe_res : '0;
    dest_d = ctl.dest;
    trap_d = ctl.legal && ctl.trap_en && exe_ovf;
    we_d   = ctl.legal && !trap_d;
    rsvd_d = !ctl.legal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result_o   <= '0;
      dest_o     <= '0;
      wr_en_o    <= 1'b0;
      ovf_trap_o <= 1'b0;
      rsvd_o     <= 1'b0;
    end else begin
      result_o   <= res_d;
      dest_o     <= dest_d;
      wr_en_o    <= we_d;
      ovf_trap_o <= trap_d;
      rsvd_o     <= rsvd_d;
    end
  end

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({wr_en_o, ovf_trap_o, rsvd_o}));

  // R4
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ovf_trap_o |-> !wr_en_o);

  // R4
  wrap_add_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (instr_i[31:26] == OPC_SPECIAL && instr_i[5:0] == FN_ADDU) |=> (wr_en_o && !ovf_trap_o));

  // R8
  rsvd_opcode_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (instr_i[31:26] == 6'h02) |=> (rsvd_o && !wr_en_o && result_o == '0));

  // R5
  slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (instr_i[31:26] == OPC_SPECIAL && instr_i[5:0] == FN_SLT) |=> (result_o[DATA_W-1:1] == '0));

  // R7
  andi_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (instr_i[31:26] == OPC_ANDI) |=> (result_o[DATA_W-1:16] == '0 && !ovf_trap_o));

  // R3
  rtype_dest_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (instr_i[31:26] == OPC_SPECIAL && instr_i[5:0] == FN_AND) |=> (dest_o == $past(instr_i[15:11])));

endmodule

// File: tb/int_alu_dec_tb_top.sv
module int_alu_dec_tb_top;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  dest;
    logic        we;
    logic        trap;
    logic        rsvd;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] rins(input logic [5:0] fn, input logic [4:0] sh);
    return {6'h00, 5'd1, 5'd2, 5'd3, sh, fn};
  endfunction

  function automatic logic [31:0] iins(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd1, 5'd9, imm};
  endfunction

  function automatic vec_t mk(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] res, input logic [4:0] dest, input logic we,
                              input logic trap, input logic rsvd, input logic [3:0] req);
    return '{ins, a, b, res, dest, we, trap, rsvd, req};
  endfunction

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    mk(rins(6'h20, 5'd0), 32'd5,        32'd7,        32'd12,       5'd3, 1, 0, 0, 3), // R3 add
    mk(rins(6'h20, 5'd0), 32'h7FFFFFFF, 32'd1,        32'h80000000, 5'd3, 0, 1, 0, 4), // R4 add ovf
    mk(rins(6'h21, 5'd0), 32'h7FFFFFFF, 32'd1,        32'h80000000, 5'd3, 1, 0, 0, 4), // R4 addu wraps
    mk(rins(6'h22, 5'd0), 32'd10,       32'd3,        32'd7,        5'd3, 1, 0, 0, 3), // R3 sub
    mk(rins(6'h22, 5'd0), 32'h80000000, 32'd1,        32'h7FFFFFFF, 5'd3, 0, 1, 0, 4), // R4 sub ovf
    mk(rins(6'h23, 5'd0), 32'd0,        32'd1,        32'hFFFFFFFF, 5'd3, 1, 0, 0, 4), // R4 subu
    mk(rins(6'h24, 5'd0), 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 5'd3, 1, 0, 0, 3), // R3 and
    mk(rins(6'h25, 5'd0), 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 5'd3, 1, 0, 0, 3), // R3 or
    mk(rins(6'h26, 5'd0), 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 5'd3, 1, 0, 0, 3), // R3 xor
    mk(rins(6'h27, 5'd0), 32'hF0F0F0F0, 32'h0F0F0000, 32'h00000F0F, 5'd3, 1, 0, 0, 3), // R3 nor
    mk(rins(6'h2A, 5'd0), 32'hFFFFFFFF, 32'd1,        32'd1,        5'd3, 1, 0, 0, 5), // R5 slt
    mk(rins(6'h2B, 5'd0), 32'hFFFFFFFF, 32'd1,        32'd0,        5'd3, 1, 0, 0, 5), // R5 sltu
    mk(rins(6'h00, 5'd31), 32'hFFFFFFFF, 32'd1,       32'h80000000, 5'd3, 1, 0, 0, 6), // R6 sll
    mk(rins(6'h02, 5'd4), 32'd0,        32'h80000000, 32'h08000000, 5'd3, 1, 0, 0, 6), // R6 srl
    mk(rins(6'h03, 5'd4), 32'd0,        32'h80000000, 32'hF8000000, 5'd3, 1, 0, 0, 6), // R6 sra
    mk(rins(6'h04, 5'd9), 32'h00000023, 32'd1,        32'd8,        5'd3, 1, 0, 0, 6), // R6 sllv
    mk(rins(6'h06, 5'd0), 32'h00000024, 32'hF0000000, 32'h0F000000, 5'd3, 1, 0, 0, 6), // R6 srlv
    mk(rins(6'h07, 5'd0), 32'h00000024, 32'hF0000000, 32'hFF000000, 5'd3, 1, 0, 0, 6), // R6 srav
    mk(iins(6'h08, 16'hFFFF), 32'd5,    32'd77,       32'd4,        5'd9, 1, 0, 0, 7), // R7 addi sext
    mk(iins(6'h08, 16'h0001), 32'h7FFFFFFF, 32'd0,    32'h80000000, 5'd9, 0, 1, 0, 4), // R4 addi ovf
    mk(iins(6'h09, 16'h0001), 32'h7FFFFFFF, 32'd0,    32'h80000000, 5'd9, 1, 0, 0, 4), // R4 addiu
    mk(iins(6'h0A, 16'hFFFF), 32'hFFFFFFFE, 32'd0,    32'd1,        5'd9, 1, 0, 0, 5), // R5 slti
    mk(iins(6'h0A, 16'hFFFF), 32'd0,    32'd0,        32'd0,        5'd9, 1, 0, 0, 5), // R5 slti false
    mk(iins(6'h0C, 16'h8001), 32'hFFFFFFFF, 32'd0,    32'h00008001, 5'd9, 1, 0, 0, 7), // R7 andi zext
    mk(iins(6'h0D, 16'hFFFF), 32'h12340000, 32'd0,    32'h1234FFFF, 5'd9, 1, 0, 0, 7), // R7 ori
    mk(iins(6'h0E, 16'h00FF), 32'hFFFFFFFF, 32'd0,    32'hFFFFFF00, 5'd9, 1, 0, 0, 7), // R7 xori
    mk(iins(6'h02, 16'h1234), 32'd1,    32'd2,        32'd0,        5'd0, 0, 0, 1, 8), // R8 opcode 0x02
    mk(rins(6'h01, 5'd0), 32'd1,        32'd2,        32'd0,        5'd0, 0, 0, 1, 8), // R8 funct 0x01
    mk(iins(6'h0B, 16'h0005), 32'd1,    32'd2,        32'd0,        5'd0, 0, 0, 1, 8)  // R8 opcode 0x0B
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en, ovf_trap, rsvd;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int_alu_dec dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_i    (instr),
    .rs_val_i   (rs_val),
    .rt_val_i   (rt_val),
    .result_o   (result),
    .dest_o     (dest),
    .wr_en_o    (wr_en),
    .ovf_trap_o (ovf_trap),
    .rsvd_o     (rsvd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_all(input string tag, input logic [31:0] er, input logic [4:0] ed,
                           input logic ew, input logic et, input logic es);
    total++;
    if (result !== er || dest !== ed || wr_en !== ew || ovf_trap !== et || rsvd !== es) begin
      bad++;
      $display("FAIL %s: got res=%h dest=%0d we=%b trap=%b rsvd=%b expected res=%h dest=%0d we=%b trap=%b rsvd=%b",
               tag, result, dest, wr_en, ovf_trap, rsvd, er, ed, ew, et, es);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got run still active expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    instr  = 32'd0;
    rs_val = 32'd0;
    rt_val = 32'd0;
    repeat (3) @(negedge clk);
    check_all("R1 during reset", 32'd0, 5'd0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release", 32'd0, 5'd0, 0, 0, 0);
    repeat (3) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      instr  = VECS[i].instr;
      rs_val = VECS[i].a;
      rt_val = VECS[i].b;
      @(negedge clk);
      check_all($sformatf("R%0d vector %0d", VECS[i].req, i),
                VECS[i].res, VECS[i].dest, VECS[i].we, VECS[i].trap, VECS[i].rsvd);
      total++;
      if ((32'(wr_en) + 32'(ovf_trap) + 32'(rsvd)) > 1) begin
        bad++;
        $display("FAIL R9 vector %0d: got flags %b%b%b expected at most one set", i, wr_en, ovf_trap, rsvd);
      end
    end

    // R2: one-cycle latency, output holds until the next edge
    instr = rins(6'h21, 5'd0); rs_val = 32'd100; rt_val = 32'd23;
    @(negedge clk);
    check_all("R2 first result", 32'd123, 5'd3, 1, 0, 0);
    instr = rins(6'h23, 5'd0); rs_val = 32'd50; rt_val = 32'd8;
    #2;
    check_all("R2 held before edge", 32'd123, 5'd3, 1, 0, 0);
    @(negedge clk);
    check_all("R2 next result", 32'd42, 5'd3, 1, 0, 0);

    // R6: variable shift ignores rs bits above bit 4 (rs=0x21 -> distance 1)
    instr = rins(6'h06, 5'd0); rs_val = 32'h00000021; rt_val = 32'h00000010;
    @(negedge clk);
    check_all("R6 srlv low bits only", 32'h00000008, 5'd3, 1, 0, 0);

    // R1: reset in mid-run clears outputs
    instr = rins(6'h20, 5'd0); rs_val = 32'd1; rt_val = 32'd1;
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check_all("R1 mid-run reset", 32'd0, 5'd0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule